// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock of a master serial interface from the system clock. A prescale counter divides the system clock by (P+1), where P is a 13-bit field, and each terminal count of that stage advances a 6-bit cycle counter. The cycle counter runs from 0 up to a wrap value W and then returns to 0, so the serial period is (P+1)·(W+1) system cycles. Two compare points in the cycle counter, a rise point and a fall point, set where the serial clock goes high and where it goes low. The duty cycle is therefore programmable and not fixed at one half.

For a master, the fall point is set equal to W so that the clock drops at the wrap, and the rise point is set to floor((W+1)/2) − 1 for a near-even duty cycle. For a slave, both points are set to 0, and the clock then stays low. A bypass input runs the sequencer at the full system rate. In bypass the divider fields have no effect: the level output is held high and both edge strobes fire on every cycle. Alongside the level, the block gives one-cycle rise and fall strobes that a transfer sequencer uses to launch and sample data. A gate input stops the clock. While the gate is low, all outputs are low and both counters return to zero.

Top module: `sclk_divider`

## Requirements
- R1: During reset, and on the cycle after any cycle in which `gate_en` is low, `sclk_o`, `rise_o` and `fall_o` are all 0. Both counters restart from 0.
- R2: In divided mode with a master setting (`fall_pt`=W, `rise_pt`=floor((W+1)/2)−1, W≥1), consecutive `rise_o` strobes are exactly (P+1)·(W+1) system cycles apart.
- R3: When the cycle counter advances onto the value `fall_pt`, `sclk_o` goes low. With a master setting, the low time is (`rise_pt`+1)·(P+1) cycles.
- R4: When the cycle counter advances onto the value `rise_pt` and that value differs from `fall_pt`, `sclk_o` goes high. The high time is (W−`rise_pt`)·(P+1) cycles.
- R5: When `rise_pt` equals `fall_pt`, the fall point wins. With both at 0 (slave setting) or otherwise equal, `sclk_o` stays low and `rise_o` never fires.
- R6: In divided mode, `rise_o` is high for exactly the one cycle in which `sclk_o` has just changed from 0 to 1.
- R7: In divided mode, `fall_o` is high for exactly the one cycle in which `sclk_o` has just changed from 1 to 0.
- R8: With `gate_en` and `bypass` both high, the following cycle has `sclk_o`, `rise_o` and `fall_o` all at 1, whatever the divider fields hold.
- R9: After `gate_en` rises, counting the first edge that samples it as edge 1, the first `rise_o` appears after edge R·(P+1). R is `rise_pt`, or W+1 when `rise_pt` is 0.
- R10: If a counter already holds a value at or beyond a newly lowered limit (P or W), it wraps to 0 on its next advance and does not run on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Clock run enable; low stops and clears the divider |
| bypass | input | 1 | Full system-rate mode, divider fields ignored |
| pre_div | input | 13 | Prescale value P; first stage divides by P+1 |
| wrap_val | input | 6 | Cycle counter wrap value W; second stage divides by W+1 |
| rise_pt | input | 6 | Cycle count at which the serial clock goes high |
| fall_pt | input | 6 | Cycle count at which the serial clock goes low |
| sclk_o | output | 1 | Registered serial clock level |
| rise_o | output | 1 | One-cycle strobe on a low-to-high change of `sclk_o` |
| fall_o | output | 1 | One-cycle strobe on a high-to-low change of `sclk_o` |

## Verification
Two events can be requested in the same cycle. The first pair is the rise and fall compares, when both points hold the same count. The second is a gate drop that lands on a cycle where a tick would otherwise move the clock. The bench provokes the first case with equal points, including the slave setting of zero, and judges that the level stays low and no rise strobe appears. It provokes the second by lowering the gate while the clock is high and judges that the next cycle shows level and strobes all at zero. A cycle-accurate model, built from the requirements, is compared on every cycle under both directed and random settings.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
  localparam int PRE_W_DEF = 13;
  localparam int CNT_W_DEF = 6;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_LOW  = 2'd2
  } edge_act_t;
endpackage

// File: rtl/sclkdiv_prescale.sv
module sclkdiv_prescale #(
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  // a count at or past the limit ends the stage, so a lowered limit wraps at once
  assign tick = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclkdiv_phase.sv
module sclkdiv_phase #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] wrap_at,
  output logic [CNT_W-1:0] next_cnt
);
  logic [CNT_W-1:0] cnt;

  assign next_cnt = (cnt >= wrap_at) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= next_cnt;
    end
  end
endmodule

// File: rtl/sclkdiv_shape.sv
module sclkdiv_shape
  import sclkdiv_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic             bypass,
  input  logic             tick,
  input  logic [CNT_W-1:0] next_cnt,
  input  logic [CNT_W-1:0] hi_pt,
  input  logic [CNT_W-1:0] lo_pt,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  edge_act_t act;

  // the fall point has priority when both compares match
  always_comb begin
    act = ACT_HOLD;
    if (next_cnt == lo_pt) begin
      act = ACT_LOW;
    end else if (next_cnt == hi_pt) begin
      act = ACT_HIGH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !gate_en) begin
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (bypass) begin
      sclk <= 1'b1;
      rise <= 1'b1;
      fall <= 1'b1;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (tick) begin
        case (act)
          ACT_HIGH: begin
            sclk <= 1'b1;
            rise <= !sclk;
          end
          ACT_LOW: begin
            sclk <= 1'b0;
            fall <= sclk;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclkdiv_pkg::*;
#(
  parameter int PRE_W = PRE_W_DEF,
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic             bypass,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [CNT_W-1:0] wrap_val,
  input  logic [CNT_W-1:0] rise_pt,
  input  logic [CNT_W-1:0] fall_pt,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic             run;
  logic             tick;
  logic [CNT_W-1:0] next_cnt;

  assign run = gate_en && !bypass;

  sclkdiv_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .limit (pre_div),
    .tick  (tick)
  );

  sclkdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .wrap_at  (wrap_val),
    .next_cnt (next_cnt)
  );

  sclkdiv_shape #(.CNT_W(CNT_W)) u_shape (
    .clk      (clk),
    .rst      (rst),
    .gate_en  (gate_en),
    .bypass   (bypass),
    .tick     (tick),
    .next_cnt (next_cnt),
    .hi_pt    (rise_pt),
    .lo_pt    (fall_pt),
    .sclk     (sclk_o),
    .rise     (rise_o),
    .fall     (fall_o)
  );
endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             gate_en,
  input logic             bypass,
  input logic [PRE_W-1:0] pre_div,
  input logic [CNT_W-1:0] wrap_val,
  input logic [CNT_W-1:0] rise_pt,
  input logic [CNT_W-1:0] fall_pt,
  input logic             sclk_o,
  input logic             rise_o,
  input logic             fall_o
);
  p_gate_off_r1: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> (!sclk_o && !rise_o && !fall_o));

  p_bypass_all_high_r8: assert property (@(posedge clk) disable iff (rst)
    (gate_en && bypass) |=> (sclk_o && rise_o && fall_o));

  p_rise_on_up_r6: assert property (@(posedge clk) disable iff (rst)
    (rise_o && !fall_o) |-> (sclk_o && !$past(sclk_o)));

  p_fall_on_down_r7: assert property (@(posedge clk) disable iff (rst)
    (fall_o && !rise_o) |-> (!sclk_o && $past(sclk_o)));

  p_change_strobed_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(gate_en && !bypass) && (sclk_o != $past(sclk_o))) |-> (rise_o || fall_o));

  p_equal_points_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $past(gate_en && !bypass && (rise_pt == fall_pt)) |-> !rise_o);
endmodule

bind sclk_divider sclk_divider_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_sclk_divider.sv
module test_sclk_divider;
  localparam int PW = 13;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          gate_en = 1'b0;
  logic          bypass = 1'b0;
  logic [PW-1:0] pre_div = '0;
  logic [CW-1:0] wrap_val = '0;
  logic [CW-1:0] rise_pt = '0;
  logic [CW-1:0] fall_pt = '0;
  logic          sclk_o, rise_o, fall_o;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    cmp_en = 1'b0;
  int    wd = 0;

  always #5 clk = ~clk;

  sclk_divider i_sclk_divider (
    .clk(clk), .rst(rst), .gate_en(gate_en), .bypass(bypass),
    .pre_div(pre_div), .wrap_val(wrap_val), .rise_pt(rise_pt), .fall_pt(fall_pt),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  // reference model written from the requirements
  logic [PW-1:0] m_pre = '0;
  logic [CW-1:0] m_cnt = '0;
  logic          m_s = 1'b0, m_r = 1'b0, m_f = 1'b0;

  always @(posedge clk) begin
    logic          t;
    logic [CW-1:0] c;
    logic          ns;
    if (rst || !gate_en) begin
      m_pre <= '0; m_cnt <= '0; m_s <= 1'b0; m_r <= 1'b0; m_f <= 1'b0;
    end else if (bypass) begin
      m_pre <= '0; m_cnt <= '0; m_s <= 1'b1; m_r <= 1'b1; m_f <= 1'b1;
    end else begin
      t  = (m_pre >= pre_div);
      c  = (m_cnt >= wrap_val) ? '0 : m_cnt + 1'b1;
      ns = m_s;
      if (t) begin
        if (c == fall_pt) ns = 1'b0;
        else if (c == rise_pt) ns = 1'b1;
      end
      m_pre <= t ? '0 : m_pre + 1'b1;
      if (t) m_cnt <= c;
      m_s <= ns;
      m_r <= t && !m_s && ns;
      m_f <= t && m_s && !ns;
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(sclk_o == m_s, tag, sclk_o, m_s);
      chk(rise_o == m_r, tag, rise_o, m_r);
      chk(fall_o == m_f, tag, fall_o, m_f);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired (R1) actual=%0d expected=%0d", wd, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_rise(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!rise_o && n < 20000);
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!fall_o && n < 20000);
  endtask

  function automatic int first_rise(input int p, input int w, input int h);
    return ((h == 0) ? (w + 1) : h) * (p + 1);
  endfunction

  // restart divider with master settings, then measure R9, R4, R3, R2
  task automatic master_run(input int p, input int w);
    int n, hi_t, lo_t, h;
    h = (w + 1) / 2 - 1;
    gate_en = 1'b0; bypass = 1'b0;
    pre_div = PW'(p); wrap_val = CW'(w); rise_pt = CW'(h); fall_pt = CW'(w);
    @(negedge clk);
    gate_en = 1'b1;
    wait_rise(n);
    chk(n == first_rise(p, w, h), "R9 first rise delay", n, first_rise(p, w, h));
    wait_fall(hi_t);
    chk(hi_t == (w - h) * (p + 1), "R4 high time", hi_t, (w - h) * (p + 1));
    wait_rise(lo_t);
    chk(lo_t == (h + 1) * (p + 1), "R3 low time", lo_t, (h + 1) * (p + 1));
    chk(hi_t + lo_t == (p + 1) * (w + 1), "R2 period", hi_t + lo_t, (p + 1) * (w + 1));
  endtask

  initial begin
    int n;
    int rises;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    chk(!sclk_o && !rise_o && !fall_o, "R1 reset outputs", {sclk_o, rise_o, fall_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp_en = 1'b1;

    // directed masters
    tag = "R2 R3 R4 directed";
    master_run(0, 3);
    master_run(2, 1);
    master_run(1, 6);

    // random masters
    tag = "R2 R3 R4 random";
    for (int i = 0; i < 8; i++) begin
      master_run(int'($urandom % 5), 1 + int'($urandom % 14));
    end

    // rise strobe and fall strobe shapes checked by model: R6 R7
    tag = "R6 R7 strobe shape";
    master_run(3, 4);
    repeat (60) @(negedge clk);

    // gate drop while high: R1
    wait (sclk_o == 1'b1);
    @(negedge clk);
    gate_en = 1'b0;
    @(negedge clk);
    chk(!sclk_o && !rise_o && !fall_o, "R1 gate drop", {sclk_o, rise_o, fall_o}, 0);

    // equal compare points, fall wins: R5
    tag = "R5 equal points";
    pre_div = 1; wrap_val = 5; rise_pt = 2; fall_pt = 2;
    gate_en = 1'b1;
    rises = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rise_o || sclk_o) rises++;
    end
    chk(rises == 0, "R5 equal points no rise", rises, 0);
    rise_pt = 0; fall_pt = 0;
    rises = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rise_o || sclk_o) rises++;
    end
    chk(rises == 0, "R5 slave zeros stay low", rises, 0);

    // bypass with random fields: R8
    tag = "R8 bypass";
    bypass = 1'b1;
    for (int i = 0; i < 40; i++) begin
      pre_div = PW'($urandom); wrap_val = CW'($urandom);
      rise_pt = CW'($urandom); fall_pt = CW'($urandom);
      @(negedge clk);
      chk(sclk_o && rise_o && fall_o, "R8 bypass outputs", {sclk_o, rise_o, fall_o}, 7);
    end
    bypass = 1'b0;

    // lowered limits while counters sit above them: R10
    tag = "R10 lowered limit";
    gate_en = 1'b0;
    pre_div = 6; wrap_val = 40; rise_pt = 19; fall_pt = 40;
    @(negedge clk);
    gate_en = 1'b1;
    repeat (200) @(negedge clk);
    pre_div = 0; wrap_val = 3; rise_pt = 1; fall_pt = 3;
    wait_rise(n);
    chk(n < 400, "R10 recovers after wrap", n, 400);
    wait_fall(n);
    chk(n == 2, "R10 high time after wrap", n, 2);
    repeat (50) @(negedge clk);

    // random mixed stimulus against model
    tag = "R1 R6 R7 random mix";
    for (int i = 0; i < 300; i++) begin
      gate_en = ($urandom % 16) != 0;
      bypass  = ($urandom % 12) == 0;
      if ($urandom % 8 == 0) begin
        pre_div = PW'($urandom % 4); wrap_val = CW'($urandom % 10);
        rise_pt = CW'($urandom % 10); fall_pt = CW'($urandom % 10);
      end
      repeat (1 + $urandom % 20) @(negedge clk);
    end

    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule